// File: doc/BRIEF.md
# Pulse-Aligned Day and MJD Timestamp Counter

This block holds the time-of-day that a packet framer writes into its headers. It keeps two values. One is the second within the current day, from 0 to 86399. The other is the low three decimal digits of the Modified Julian Day. A host writes a new time at any point. The block holds that value and applies it on the next rising edge of the once-per-second pulse. After the load, each pulse adds one second. When the last second of a day passes, the second count returns to zero and the day digits step up by one.

The pulse comes from one of two pins, chosen by a select input: an internal test pulse or an external reference. The second of day is available in binary and as five packed BCD digits. The day digits are held in BCD only. A valid flag tells the framer when the time has been loaded. Host writes with a second count outside the day or with a non-decimal day digit are ignored.

Top module: `pps_timestamp_clock`

## Requirements
- R1: While reset is asserted, `sod_bin`, `sod_bcd` and `mjd_bcd` are zero and `time_valid` is low.
- R2: A host write (`wr_en` high for one cycle) changes no output. The outputs change only at the first clock edge at which the selected pulse pin is sampled high after being sampled low.
- R3: At the first pulse edge after a write, `sod_bin` takes `wr_sod` and `mjd_bcd` takes `wr_mjd`, and `time_valid` goes high. Once high, `time_valid` stays high until reset.
- R4: At a pulse edge with no write held and `time_valid` high, `sod_bin` increases by exactly one and `mjd_bcd` is unchanged.
- R5: At a pulse edge with no write held and `sod_bin` equal to 86399, `sod_bin` becomes 0 and the day value increases by one. The decimal carry ripples between digits, so 099 becomes 100.
- R6: The day value 999 steps to 000 on a day rollover.
- R7: `sod_bcd` always holds the decimal form of `sod_bin`, least significant digit in bits 3:0, four bits per digit.
- R8: When `pps_src` is 0 the pulse comes from `pps_int`; when it is 1 it comes from `pps_ext`. Edges on the pin that is not selected have no effect.
- R9: If a write and a pulse edge fall in the same cycle, that edge loads any earlier held write, or else steps the time. The new write is held for the following edge.
- R10: A write with `wr_sod` above 86399, or with any nibble of `wr_mjd` above 9, is discarded. Any write already held stays held.
- R11: Before the first load, pulse edges leave the time at zero and `time_valid` low.
- R12: A held write is applied by one edge only. If several writes come before an edge, the last valid one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_int | input | 1 | Internal test second pulse |
| pps_ext | input | 1 | External second pulse |
| pps_src | input | 1 | Pulse source select: 0 internal, 1 external |
| wr_en | input | 1 | Host write strobe for a new time |
| wr_sod | input | 17 | Second of day to load, binary |
| wr_mjd | input | 12 | Day digits to load, three BCD nibbles |
| sod_bin | output | 17 | Current second of day, binary |
| sod_bcd | output | 20 | Current second of day, five BCD nibbles |
| mjd_bcd | output | 12 | Current day digits, three BCD nibbles |
| time_valid | output | 1 | High once a written time has been loaded |

## Verification
The hardest case to reach is a host write that lands in the same cycle as a pulse edge. The held value and the new one then have to be told apart at the outputs. The bench raises the write strobe and the pulse pin at the same falling edge. It checks that the first edge only steps the time and that the next edge loads the new value. The day rollover is reached by loading 86398 or 86399 together with day digits 999 or 099. A few pulses then drive the ripple carry and the 999 wrap, with no need to count through a full day.

// File: rtl/pps_timestamp_clock.sv
module pps_timestamp_clock #(
  parameter int DAY_SECONDS = 86400,
  parameter int MJD_DIGITS  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pps_int,
  input  logic                         pps_ext,
  input  logic                         pps_src,
  input  logic                         wr_en,
  input  logic [$clog2(DAY_SECONDS)-1:0] wr_sod,
  input  logic [4*MJD_DIGITS-1:0]      wr_mjd,
  output logic [$clog2(DAY_SECONDS)-1:0] sod_bin,
  output logic [4*((DAY_SECONDS > 10000) ? 5 : 4)-1:0] sod_bcd,
  output logic [4*MJD_DIGITS-1:0]      mjd_bcd,
  output logic                         time_valid
);

  function automatic int digits_of(input int v);
    int n;
    n = 1;
    while (v >= 10) begin
      v = v / 10;
      n++;
    end
    return n;
  endfunction

  localparam int SOD_W      = $clog2(DAY_SECONDS);
  localparam int SOD_DIGITS = (DAY_SECONDS > 10000) ? 5 : 4;
  localparam int SOD_BCD_W  = 4 * SOD_DIGITS;
  localparam int MJD_W      = 4 * MJD_DIGITS;
  localparam int NEED_DIG   = digits_of(DAY_SECONDS - 1);
  localparam logic [SOD_W-1:0] SOD_LAST = SOD_W'(DAY_SECONDS - 1);

  initial begin
    if (NEED_DIG > SOD_DIGITS) $error("DAY_SECONDS needs more BCD digits than provided");
  end

  function automatic logic [SOD_BCD_W-1:0] to_bcd(input logic [SOD_W-1:0] b);
    logic [SOD_BCD_W-1:0] r;
    r = '0;
    for (int i = SOD_W - 1; i >= 0; i--) begin
      for (int d = 0; d < SOD_DIGITS; d++) begin
        if (r[4*d +: 4] >= 4'd5) r[4*d +: 4] = r[4*d +: 4] + 4'd3;
      end
      r = {r[SOD_BCD_W-2:0], b[i]};
    end
    return r;
  endfunction

  function automatic logic digits_ok(input logic [MJD_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < MJD_DIGITS; d++) begin
      if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  logic                 pps_lvl, pps_prev, pps_edge;
  logic                 wr_ok, day_end;
  logic                 stg_pend;
  logic [SOD_W-1:0]     stg_sod;
  logic [SOD_BCD_W-1:0] stg_sod_bcd;
  logic [MJD_W-1:0]     stg_mjd;
  logic [SOD_W-1:0]     sod_q;
  logic [SOD_BCD_W-1:0] sod_bcd_q, sod_bcd_nx;
  logic [MJD_W-1:0]     mjd_q, mjd_nx;
  logic                 valid_q;
  logic [SOD_DIGITS-1:0] sod_cin;
  logic [MJD_DIGITS-1:0] mjd_cin;

  assign pps_lvl  = pps_src ? pps_ext : pps_int;
  assign pps_edge = pps_lvl & ~pps_prev;
  assign wr_ok    = wr_en && (wr_sod <= SOD_LAST) && digits_ok(wr_mjd);
  assign day_end  = (sod_q == SOD_LAST);

  genvar g;
  generate
    for (g = 0; g < SOD_DIGITS; g++) begin : g_sod_dig
      if (g == 0) begin : g_first
        assign sod_cin[g] = 1'b1;
      end else begin : g_rest
        assign sod_cin[g] = sod_cin[g-1] & (sod_bcd_q[4*(g-1) +: 4] == 4'd9);
      end
      assign sod_bcd_nx[4*g +: 4] = !sod_cin[g] ? sod_bcd_q[4*g +: 4] :
                                    (sod_bcd_q[4*g +: 4] == 4'd9) ? 4'd0 :
                                    sod_bcd_q[4*g +: 4] + 4'd1;
    end
    for (g = 0; g < MJD_DIGITS; g++) begin : g_mjd_dig
      if (g == 0) begin : g_first
        assign mjd_cin[g] = 1'b1;
      end else begin : g_rest
        assign mjd_cin[g] = mjd_cin[g-1] & (mjd_q[4*(g-1) +: 4] == 4'd9);
      end
      assign mjd_nx[4*g +: 4] = !mjd_cin[g] ? mjd_q[4*g +: 4] :
                                (mjd_q[4*g +: 4] == 4'd9) ? 4'd0 :
                                mjd_q[4*g +: 4] + 4'd1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pps_prev <= 1'b0;
    else        pps_prev <= pps_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_pend    <= 1'b0;
      stg_sod     <= '0;
      stg_sod_bcd <= '0;
      stg_mjd     <= '0;
    end else if (wr_ok) begin
      stg_pend    <= 1'b1;
      stg_sod     <= wr_sod;
      stg_sod_bcd <= to_bcd(wr_sod);
      stg_mjd     <= wr_mjd;
    end else if (pps_edge) begin
      stg_pend    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sod_q     <= '0;
      sod_bcd_q <= '0;
      mjd_q     <= '0;
      valid_q   <= 1'b0;
    end else if (pps_edge) begin
      if (stg_pend) begin
        sod_q     <= stg_sod;
        sod_bcd_q <= stg_sod_bcd;
        mjd_q     <= stg_mjd;
        valid_q   <= 1'b1;
      end else if (valid_q) begin
        if (day_end) begin
          sod_q     <= '0;
          sod_bcd_q <= '0;
          mjd_q     <= mjd_nx;
        end else begin
          sod_q     <= sod_q + 1'b1;
          sod_bcd_q <= sod_bcd_nx;
        end
      end
    end
  end

  assign sod_bin    = sod_q;
  assign sod_bcd    = sod_bcd_q;
  assign mjd_bcd    = mjd_q;
  assign time_valid = valid_q;

endmodule

// File: rtl/pps_timestamp_clock_chk.sv
module pps_timestamp_clock_chk #(
  parameter int DAY_SECONDS = 86400,
  parameter int MJD_DIGITS  = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           pps_int,
  input logic                           pps_ext,
  input logic                           pps_src,
  input logic                           stg_pend,
  input logic [$clog2(DAY_SECONDS)-1:0] sod_bin,
  input logic [4*((DAY_SECONDS > 10000) ? 5 : 4)-1:0] sod_bcd,
  input logic [4*MJD_DIGITS-1:0]        mjd_bcd,
  input logic                           time_valid
);

  localparam int SOD_W      = $clog2(DAY_SECONDS);
  localparam int SOD_DIGITS = (DAY_SECONDS > 10000) ? 5 : 4;
  localparam int MJD_MOD    = 10 ** MJD_DIGITS;
  localparam logic [SOD_W-1:0] LAST = SOD_W'(DAY_SECONDS - 1);

  function automatic int sod_dec(input logic [4*SOD_DIGITS-1:0] b);
    int acc;
    acc = 0;
    for (int d = SOD_DIGITS - 1; d >= 0; d--) acc = acc * 10 + int'(b[4*d +: 4]);
    return acc;
  endfunction

  function automatic int mjd_dec(input logic [4*MJD_DIGITS-1:0] b);
    int acc;
    acc = 0;
    for (int d = MJD_DIGITS - 1; d >= 0; d--) acc = acc * 10 + int'(b[4*d +: 4]);
    return acc;
  endfunction

  logic seen_prev, seen_edge;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_prev <= 1'b0;
    else        seen_prev <= pps_src ? pps_ext : pps_int;
  end
  assign seen_edge = (pps_src ? pps_ext : pps_int) && !seen_prev;

  p_bcd_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sod_bin) == sod_dec(sod_bcd));

  p_in_day_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sod_bin) < DAY_SECONDS);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_edge |=> $stable(sod_bin) && $stable(mjd_bcd) && $stable(time_valid));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |=> time_valid);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge && stg_pend |=> time_valid);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge && time_valid && !stg_pend && sod_bin != LAST |=>
      sod_bin == $past(sod_bin) + 1'b1 && $stable(mjd_bcd));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge && time_valid && !stg_pend && sod_bin == LAST |=>
      sod_bin == '0 && mjd_dec(mjd_bcd) == (mjd_dec($past(mjd_bcd)) + 1) % MJD_MOD);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge && !time_valid && !stg_pend |=> !time_valid && sod_bin == '0);

endmodule

bind pps_timestamp_clock pps_timestamp_clock_chk #(
  .DAY_SECONDS(DAY_SECONDS),
  .MJD_DIGITS (MJD_DIGITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pps_int   (pps_int),
  .pps_ext   (pps_ext),
  .pps_src   (pps_src),
  .stg_pend  (stg_pend),
  .sod_bin   (sod_bin),
  .sod_bcd   (sod_bcd),
  .mjd_bcd   (mjd_bcd),
  .time_valid(time_valid)
);

// File: tb/test_pps_timestamp_clock.sv
module test_pps_timestamp_clock;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_int = 1'b0, pps_ext = 1'b0, pps_src = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_sod = '0;
  logic [11:0] wr_mjd = '0;
  logic [16:0] sod_bin;
  logic [19:0] sod_bcd;
  logic [11:0] mjd_bcd;
  logic        time_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_timestamp_clock i_pps_timestamp_clock (
    .clk(clk), .rst_n(rst_n), .pps_int(pps_int), .pps_ext(pps_ext),
    .pps_src(pps_src), .wr_en(wr_en), .wr_sod(wr_sod), .wr_mjd(wr_mjd),
    .sod_bin(sod_bin), .sod_bcd(sod_bcd), .mjd_bcd(mjd_bcd),
    .time_valid(time_valid)
  );

  // fields: req[64:61] op[60:59] sod[58:42] mjd[41:30] esod[29:13] emjd[12:1] ev[0]
  // op 0 = pulse on internal pin, op 1 = host write
  localparam logic [64:0] VEC [NVEC] = '{
    {4'd11, 2'd0, 17'd0,     12'h000, 17'd0,     12'h000, 1'b0}, // R11 pulse before load
    {4'd2,  2'd1, 17'd86398, 12'h999, 17'd0,     12'h000, 1'b0}, // R2 write waits
    {4'd3,  2'd0, 17'd0,     12'h000, 17'd86398, 12'h999, 1'b1}, // R3 load
    {4'd4,  2'd0, 17'd0,     12'h000, 17'd86399, 12'h999, 1'b1}, // R4 step
    {4'd6,  2'd0, 17'd0,     12'h000, 17'd0,     12'h000, 1'b1}, // R5 R6 rollover 999->000
    {4'd4,  2'd0, 17'd0,     12'h000, 17'd1,     12'h000, 1'b1},
    {4'd2,  2'd1, 17'd100,   12'h123, 17'd1,     12'h000, 1'b1},
    {4'd12, 2'd1, 17'd200,   12'h456, 17'd1,     12'h000, 1'b1}, // R12 last write wins
    {4'd12, 2'd0, 17'd0,     12'h000, 17'd200,   12'h456, 1'b1},
    {4'd12, 2'd0, 17'd0,     12'h000, 17'd201,   12'h456, 1'b1}, // R12 used once
    {4'd10, 2'd1, 17'd90000, 12'h001, 17'd201,   12'h456, 1'b1}, // R10 sod out of day
    {4'd10, 2'd0, 17'd0,     12'h000, 17'd202,   12'h456, 1'b1},
    {4'd10, 2'd1, 17'd500,   12'h12A, 17'd202,   12'h456, 1'b1}, // R10 bad digit
    {4'd10, 2'd0, 17'd0,     12'h000, 17'd203,   12'h456, 1'b1}
  };

  function automatic logic [19:0] dec5(input int v);
    logic [19:0] r;
    for (int d = 0; d < 5; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input int req, input int esod, input logic [11:0] emjd, input logic ev);
    total++;
    if (sod_bin !== 17'(esod) || sod_bcd !== dec5(esod) || mjd_bcd !== emjd || time_valid !== ev) begin
      bad++;
      $display("FAIL R%0d: sod=%0d bcd=%h mjd=%h valid=%b expected sod=%0d bcd=%h mjd=%h valid=%b",
               req, sod_bin, sod_bcd, mjd_bcd, time_valid, esod, dec5(esod), emjd, ev);
    end
  endtask

  task automatic pulse(input bit ext);
    @(negedge clk);
    if (ext) pps_ext = 1'b1; else pps_int = 1'b1;
    @(negedge clk);
    pps_ext = 1'b0;
    pps_int = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_write(input int s, input logic [11:0] m);
    @(negedge clk);
    wr_en = 1'b1;
    wr_sod = 17'(s);
    wr_mjd = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 0, 12'h000, 1'b0); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][60:59] == 2'd1) host_write(int'(VEC[i][58:42]), VEC[i][41:30]);
      else pulse(1'b0);
      @(negedge clk);
      check(int'(VEC[i][64:61]), int'(VEC[i][29:13]), VEC[i][12:1], VEC[i][0]);
    end

    // R8: unselected pin ignored, selected pin counts
    pulse(1'b1);
    check(8, 203, 12'h456, 1'b1);
    @(negedge clk) pps_src = 1'b1;
    pulse(1'b1);
    check(8, 204, 12'h456, 1'b1);
    pulse(1'b0);
    check(8, 204, 12'h456, 1'b1);
    @(negedge clk) pps_src = 1'b0;

    // R9: write and pulse in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sod = 17'd1000; wr_mjd = 12'h777; pps_int = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pps_int = 1'b0;
    @(negedge clk);
    check(9, 205, 12'h456, 1'b1);
    pulse(1'b0);
    check(9, 1000, 12'h777, 1'b1);

    // R10: a rejected write keeps the earlier held value
    host_write(300, 12'h001);
    host_write(90000, 12'h002);
    pulse(1'b0);
    check(10, 300, 12'h001, 1'b1);

    // R5: decimal carry across day digits
    host_write(86399, 12'h099);
    pulse(1'b0);
    check(5, 86399, 12'h099, 1'b1);
    pulse(1'b0);
    check(5, 0, 12'h100, 1'b1);

    // R7 with many digits changing: 9999 -> 10000
    host_write(9999, 12'h500);
    pulse(1'b0);
    pulse(1'b0);
    check(7, 10000, 12'h500, 1'b1);

    // R1: reset in the middle of operation
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(1, 0, 12'h000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    pulse(1'b0);
    check(11, 0, 12'h000, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule